// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a three-wire stereo audio stream into parallel samples. It runs entirely on the serial bit clock, which serves as its only clock. On every rising edge it samples the data line and the left/right word clock. A 2-bit format selector picks one of four framings: 16-bit right-aligned, 18-bit right-aligned, 18-bit left-aligned and the I2S-compatible layout. Data is always sent most significant bit first and in two's complement.

At the end of each word-clock half-period, the block decides whether the half-period that just finished held enough bits for the chosen format. If it did, the block presents one 18-bit sample together with a channel flag and a one-cycle valid strobe. If it did not, the bits are dropped and a one-cycle framing-error strobe is raised instead. The output is a pure stream with no ready input. The source cannot be paused, so the sink must accept a sample in the same cycle its strobe is high. The sample and channel outputs hold their values between strobes. The format selector must only be changed while reset is asserted.

Top module: `sar_rx`

## Requirements
- R1: The format selector is decoded as 2'b00 = 16-bit right-aligned, 2'b01 = 18-bit right-aligned, 2'b10 = 18-bit left-aligned, 2'b11 = I2S-compatible. Data and word clock are sampled on each rising clock edge, and bits arrive most significant first.
- R2: In 16-bit right-aligned mode, the sample is the last 16 bits sampled before the cycle in which the new word-clock level is first seen. The most significant of those bits is the sign, and it is copied into output bits 17 and 16.
- R3: In 18-bit right-aligned mode, the sample is the last 18 bits sampled before the cycle in which the new word-clock level is first seen.
- R4: In 18-bit left-aligned mode, the most significant bit is the one sampled in the first cycle that sees the new word-clock level, and the next 17 bits follow. A 16-bit stream sent with two zero low bits comes out with zero in bits 1:0.
- R5: In I2S-compatible mode, the word boundary lies one bit clock after each word-clock transition. The most significant bit is sampled one cycle after the first cycle that sees the new level. A word that ends before its 18th bit has its missing low bits filled with zero.
- R6: sample_left is 1 for a word sent while the word clock was high in the three justified modes, and for a word sent while it was low in I2S-compatible mode.
- R7: sample_valid pulses high for exactly one cycle, in the cycle after the clock edge at which the half-period is found to have ended. sample and sample_left change only together with that pulse.
- R8: A half-period is complete with at least 16 bits in modes 00 and 11, and at least 18 bits in modes 01 and 10. A shorter one raises frame_err for one cycle with no sample_valid, and leaves sample and sample_left unchanged.
- R9: Synchronous reset clears sample, sample_left, sample_valid and frame_err. Neither strobe rises until a full half-period, bounded by two word boundaries after reset, has ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Framing format selector (see R1) |
| lrck | input | 1 | Left/right word clock |
| sdata | input | 1 | Serial data line |
| sample | output | 18 | Received two's-complement sample |
| sample_left | output | 1 | 1 when sample belongs to the left channel |
| sample_valid | output | 1 | One-cycle strobe: sample is new |
| frame_err | output | 1 | One-cycle strobe: a half-period was too short |

## Verification
The hardest case to reach is a half-period whose length sits right at the format's limit. Examples are 15, 16 and 17 bits in I2S-compatible mode, where 16 and 17 give a zero-filled sample and 15 gives an error, and 17 against 18 bits in the 18-bit modes. The bench builds such streams by setting the number of bit clocks per half-period directly. It mixes these short streams with normal ones, and it asserts reset in the middle of a stream. A behavioural queue model rebuilds every expected word from the raw bits it has driven, and the outputs are compared against it on every clock.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    FMT_RJ_SHORT = 2'b00,
    FMT_RJ_LONG  = 2'b01,
    FMT_LJ_LONG  = 2'b10,
    FMT_I2S      = 2'b11
  } fmt_e;

  // fewest bits a half-period must carry to yield a sample
  function automatic int min_bits(fmt_e f, int short_w, int long_w, int i2s_min);
    case (f)
      FMT_RJ_SHORT: min_bits = short_w;
      FMT_RJ_LONG:  min_bits = long_w;
      FMT_LJ_LONG:  min_bits = long_w;
      default:      min_bits = i2s_min;
    endcase
  endfunction

endpackage

// File: rtl/sar_edge_tracker.sv
module sar_edge_tracker #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wclk,
  output logic             edge_now,
  output logic             synced,
  output logic [CNT_W-1:0] half_len,
  output logic             half_lvl,
  output logic [CNT_W-1:0] pos
);

  localparam logic [CNT_W-1:0] LEN_MAX = {CNT_W{1'b1}};

  logic             primed;
  logic             prev_lvl;
  logic [CNT_W-1:0] len_q;

  assign edge_now = primed && (wclk != prev_lvl);
  assign half_len = len_q;
  assign half_lvl = prev_lvl;
  assign pos      = edge_now ? '0 : len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      primed   <= 1'b0;
      synced   <= 1'b0;
      prev_lvl <= 1'b0;
      len_q    <= '0;
    end else if (!primed) begin
      primed   <= 1'b1;
      prev_lvl <= wclk;
      len_q    <= CNT_W'(1);
    end else begin
      prev_lvl <= wclk;
      if (edge_now) begin
        synced <= 1'b1;
        len_q  <= CNT_W'(1);
      end else if (len_q != LEN_MAX) begin
        len_q <= len_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/sar_bit_capture.sv
module sar_bit_capture #(
  parameter int W     = 18,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sdata,
  input  logic [CNT_W-1:0] pos,
  output logic [W-1:0]     tail_bits,
  output logic [W-1:0]     head_bits
);

  localparam int IDX_W = $clog2(W);
  localparam logic [CNT_W-1:0] W_C = CNT_W'(W);

  logic [IDX_W-1:0] slot;
  assign slot = IDX_W'(W - 1) - pos[IDX_W-1:0];

  // trailing window: always the newest W bits
  always_ff @(posedge clk) begin
    if (rst) tail_bits <= '0;
    else     tail_bits <= {tail_bits[W-2:0], sdata};
  end

  // leading window: bit at position p of the half lands at W-1-p
  always_ff @(posedge clk) begin
    if (rst) begin
      head_bits <= '0;
    end else if (pos == '0) begin
      head_bits <= {sdata, {(W-1){1'b0}}};
    end else if (pos < W_C) begin
      head_bits[slot] <= sdata;
    end
  end

endmodule

// File: rtl/sar_sample_former.sv
module sar_sample_former
  import sar_pkg::*;
#(
  parameter int W       = 18,
  parameter int SHORT_W = 16,
  parameter int I2S_MIN = 16,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  fmt_e             fmt,
  input  logic             edge_now,
  input  logic             synced,
  input  logic [CNT_W-1:0] half_len,
  input  logic             half_lvl,
  input  logic [W-1:0]     tail_bits,
  input  logic [W-1:0]     head_bits,
  output logic [W-1:0]     sample,
  output logic             sample_left,
  output logic             sample_valid,
  output logic             frame_err
);

  localparam int EXT_W = W - SHORT_W;

  logic [W-1:0] word;
  logic         enough;
  logic         left_now;

  generate
    if (EXT_W > 0) begin : g_ext
      logic [W-1:0] short_word;
      assign short_word = {{EXT_W{tail_bits[SHORT_W-1]}}, tail_bits[SHORT_W-1:0]};
      always_comb begin
        case (fmt)
          FMT_RJ_SHORT: word = short_word;
          FMT_RJ_LONG:  word = tail_bits;
          default:      word = head_bits;
        endcase
      end
    end else begin : g_noext
      always_comb begin
        case (fmt)
          FMT_RJ_SHORT, FMT_RJ_LONG: word = tail_bits;
          default:                   word = head_bits;
        endcase
      end
    end
  endgenerate

  assign enough   = int'(half_len) >= min_bits(fmt, SHORT_W, W, I2S_MIN);
  assign left_now = (fmt == FMT_I2S) ? !half_lvl : half_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      sample       <= '0;
      sample_left  <= 1'b0;
      sample_valid <= 1'b0;
      frame_err    <= 1'b0;
    end else begin
      sample_valid <= 1'b0;
      frame_err    <= 1'b0;
      if (edge_now && synced) begin
        if (enough) begin
          sample       <= word;
          sample_left  <= left_now;
          sample_valid <= 1'b1;
        end else begin
          frame_err <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sar_rx.sv
module sar_rx
  import sar_pkg::*;
#(
  parameter int SAMPLE_W = 18,
  parameter int SHORT_W  = 16,
  parameter int I2S_MIN  = 16,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          mode,
  input  logic                lrck,
  input  logic                sdata,
  output logic [SAMPLE_W-1:0] sample,
  output logic                sample_left,
  output logic                sample_valid,
  output logic                frame_err
);

  fmt_e             fmt;
  logic             lrck_d1;
  logic             wclk_eff;
  logic             edge_now;
  logic             synced;
  logic [CNT_W-1:0] half_len;
  logic             half_lvl;
  logic [CNT_W-1:0] pos;
  logic [SAMPLE_W-1:0] tail_bits;
  logic [SAMPLE_W-1:0] head_bits;

  assign fmt = fmt_e'(mode);

  // delayed word clock, kept live through reset so no false edge follows it
  always_ff @(posedge clk) lrck_d1 <= lrck;

  assign wclk_eff = (fmt == FMT_I2S) ? lrck_d1 : lrck;

  sar_edge_tracker #(.CNT_W(CNT_W)) trk_i (
    .clk      (clk),
    .rst      (rst),
    .wclk     (wclk_eff),
    .edge_now (edge_now),
    .synced   (synced),
    .half_len (half_len),
    .half_lvl (half_lvl),
    .pos      (pos)
  );

  sar_bit_capture #(.W(SAMPLE_W), .CNT_W(CNT_W)) cap_i (
    .clk       (clk),
    .rst       (rst),
    .sdata     (sdata),
    .pos       (pos),
    .tail_bits (tail_bits),
    .head_bits (head_bits)
  );

  sar_sample_former #(
    .W(SAMPLE_W), .SHORT_W(SHORT_W), .I2S_MIN(I2S_MIN), .CNT_W(CNT_W)
  ) frm_i (
    .clk          (clk),
    .rst          (rst),
    .fmt          (fmt),
    .edge_now     (edge_now),
    .synced       (synced),
    .half_len     (half_len),
    .half_lvl     (half_lvl),
    .tail_bits    (tail_bits),
    .head_bits    (head_bits),
    .sample       (sample),
    .sample_left  (sample_left),
    .sample_valid (sample_valid),
    .frame_err    (frame_err)
  );

endmodule

// File: rtl/sar_rx_chk.sv
module sar_rx_chk #(
  parameter int SAMPLE_W = 18,
  parameter int SHORT_W  = 16
) (
  input logic                clk,
  input logic                rst,
  input logic [1:0]          mode,
  input logic [SAMPLE_W-1:0] sample,
  input logic                sample_valid,
  input logic                frame_err
);

  // R8
  valid_err_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(sample_valid && frame_err));

  // R7
  valid_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> !sample_valid);

  // R7
  sample_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (sample != $past(sample))) |-> sample_valid);

  // R9
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sample_valid && !frame_err && sample == '0));

  // R2
  short_sign_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && mode == 2'b00) |->
      (sample[SAMPLE_W-1:SHORT_W-1] == '0 || sample[SAMPLE_W-1:SHORT_W-1] == '1));

endmodule

bind sar_rx sar_rx_chk #(.SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .mode         (mode),
  .sample       (sample),
  .sample_valid (sample_valid),
  .frame_err    (frame_err)
);

// File: tb/sar_rx_tb_top.sv
module sar_rx_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst   = 1'b1;
  logic [1:0]  mode  = 2'b00;
  logic        lrck  = 1'b0;
  logic        sdata = 1'b0;
  logic [17:0] sample;
  logic        sample_left, sample_valid, frame_err;

  sar_rx dut_i (
    .clk(clk), .rst(rst), .mode(mode), .lrck(lrck), .sdata(sdata),
    .sample(sample), .sample_left(sample_left),
    .sample_valid(sample_valid), .frame_err(frame_err)
  );

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R9";
  bit    started = 0;
  bit    done = 0;

  // reference model state
  bit          m_primed, m_synced, m_prev, m_lrd;
  bit          q[$];
  logic [17:0] e_sample = '0;
  bit          e_left, e_valid, e_err;

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic compare();
    checks++;
    if (sample !== e_sample || sample_left !== e_left ||
        sample_valid !== e_valid || frame_err !== e_err) begin
      fails++;
      $display("FAIL %s: sample=%h left=%b valid=%b err=%b expected sample=%h left=%b valid=%b err=%b",
               cur_req, sample, sample_left, sample_valid, frame_err,
               e_sample, e_left, e_valid, e_err);
    end
  endtask

  function automatic logic [17:0] decode(int n);
    logic [17:0] v = '0;
    if (mode == 2'b00) begin
      for (int k = 0; k < 16; k++) v = {v[16:0], logic'(q[n-16+k])};
      if (v[15]) v[17:16] = 2'b11;
    end else if (mode == 2'b01) begin
      for (int k = 0; k < 18; k++) v = {v[16:0], logic'(q[n-18+k])};
    end else begin
      for (int k = 0; k < 18; k++) v[17-k] = (k < n) ? q[k] : 1'b0;
    end
    return v;
  endfunction

  // predicts outputs after the edge that samples (l, d, r)
  task automatic model(bit l, bit d, bit r);
    bit eff;
    int n, need;
    eff   = (mode == 2'b11) ? m_lrd : l;
    m_lrd = l;
    if (r) begin
      m_primed = 0; m_synced = 0; q.delete();
      e_sample = '0; e_left = 0; e_valid = 0; e_err = 0;
      return;
    end
    e_valid = 0; e_err = 0;
    if (!m_primed) begin
      m_primed = 1; m_prev = eff; q.delete(); q.push_back(d);
    end else if (eff != m_prev) begin
      if (m_synced) begin
        n    = q.size();
        need = (mode == 2'b01 || mode == 2'b10) ? 18 : 16;
        if (n < need) e_err = 1;
        else begin
          e_valid  = 1;
          e_left   = (mode == 2'b11) ? !m_prev : m_prev;
          e_sample = decode(n);
        end
      end
      m_synced = 1; m_prev = eff; q.delete(); q.push_back(d);
    end else begin
      q.push_back(d);
    end
  endtask

  task automatic step(bit l, bit d, bit r);
    @(negedge clk);
    if (started) compare();
    started = 1;
    lrck = l; sdata = d; rst = r;
    model(l, d, r);
  endtask

  task automatic do_reset(logic [1:0] m);
    mode = m;
    for (int i = 0; i < 3; i++) step(lrck, 1'b0, 1'b1);
  endtask

  // stream of halves, b bit clocks each, formatted for the current mode
  task automatic play(int halves, int b, bit pad16, bit start_lvl);
    bit lv[$];
    bit dv[$];
    for (int h = 0; h < halves; h++) begin
      logic [17:0] w = 18'($urandom);
      bit lvl = start_lvl ^ h[0];
      int nb  = (mode == 2'b00) ? 16 : 18;
      if (pad16) w[1:0] = 2'b00;
      for (int c = 0; c < b; c++) begin
        bit bv = 0;
        if (mode < 2'b10) begin
          int idx = c - (b - nb);
          if (idx >= 0 && idx < nb) bv = w[nb-1-idx];
        end else if (c < nb) begin
          bv = w[nb-1-c];
        end
        lv.push_back(lvl);
        dv.push_back(bv);
      end
    end
    for (int i = 0; i < lv.size(); i++) begin
      bit d = (mode == 2'b11) ? ((i == 0) ? 1'b0 : dv[i-1]) : dv[i];
      step(lv[i], d, 1'b0);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R9 reset state
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0);

    cur_req = "R2 R1 R6 R7";
    do_reset(2'b00);
    play(8, 16, 0, 1);
    play(6, 24, 0, 1);

    cur_req = "R3 R6 R7";
    do_reset(2'b01);
    play(8, 18, 0, 1);
    play(6, 32, 0, 1);

    cur_req = "R4 R6";
    do_reset(2'b10);
    play(8, 18, 0, 0);
    play(6, 32, 1, 0);

    cur_req = "R5 R6 R1";
    do_reset(2'b11);
    play(8, 16, 0, 0);
    play(6, 32, 0, 0);
    play(4, 17, 0, 0);

    cur_req = "R8";
    play(4, 15, 0, 0);
    play(4, 20, 0, 0);
    do_reset(2'b01);
    play(4, 17, 0, 1);
    play(4, 18, 0, 0);
    do_reset(2'b10);
    play(4, 17, 0, 1);
    do_reset(2'b00);
    play(4, 15, 0, 1);
    play(4, 16, 0, 0);

    cur_req = "R9";
    do_reset(2'b00);
    play(3, 20, 0, 1);
    for (int i = 0; i < 2; i++) step(lrck, 1'b0, 1'b1);
    play(6, 20, 0, 0);

    step(lrck, 1'b0, 1'b0);
    done = 1;
    summary();
    $finish;
  end

endmodule